// File: doc/BRIEF.md
# Page-Mode Byte Load Controller

This block is the write front end of a byte-wide parallel nonvolatile memory. It samples the active-low chip select, write enable and output enable pins through synchronisers and recognises a byte load whenever select and write enable are both low while output enable is high. For each accepted load it records the address when the combined strobe opens and the data byte when it closes. The byte goes into a page buffer at the position given by the low address bits.

Every accepted strobe opening restarts a load window, so the window behaves as a retriggerable one-shot. When the window runs out with no strobe open, the block issues a one-cycle program request. The request carries the page address, the whole buffered page and a mask of the bytes that were loaded. The block then holds busy for a fixed programming interval, or until the array stub reports that it has finished. Loads whose page differs from the first load of the burst are dropped and raise a sticky flag. Strobes that arrive while busy is high are ignored. All timer lengths are parameters counted in clock cycles.

Top module: `page_load_ctrl`

## Requirements
- R1: A byte load is recognised only while the sampled chip select and write enable are both low and output enable is high. A strobe taken with output enable low loads nothing and starts no window.
- R2: The load address is the address sampled in the first cycle where both chip select and write enable are seen low, that is, at whichever of the two falls last.
- R3: The data byte is the value sampled in the first cycle where chip select or write enable is seen high again, that is, at whichever of the two rises first.
- R4: The program request goes high exactly 2 + GLITCH_CYC + LOAD_CYC clock edges after the input edge at which the last accepted strobe of a burst goes low. Each accepted strobe restarts this count.
- R5: The program request is a one-cycle pulse. It presents the burst page, the buffered bytes and a mask where bit i set means byte offset i was loaded. A later load to the same offset overwrites the earlier byte.
- R6: Busy rises together with the program request and stays high for PROG_CYC cycles. It falls one cycle after prog_done is seen high, if that comes sooner.
- R7: Strobes that become active while busy is high load nothing, leave the buffer and mask unchanged, and start no further program request.
- R8: A load whose page bits (address above the offset bits) differ from the first load of the burst is discarded. It sets page_mismatch, which stays high until reset.
- R9: A strobe whose active phase lasts fewer than GLITCH_CYC sampled cycles is rejected. One that lasts exactly GLITCH_CYC cycles is accepted.
- R10: After reset, busy, prog_req, page_mismatch and prog_mask are all zero.
- R11: The byte offset is address bits [log2(PAGE_BYTES)-1:0]. Offset PAGE_BYTES-1 maps to mask bit PAGE_BYTES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous to clk |
| we_n | input | 1 | Write enable, active low, asynchronous to clk |
| oe_n | input | 1 | Output enable, active low, asynchronous to clk |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data byte |
| prog_done | input | 1 | Array stub reports programming finished |
| prog_req | output | 1 | One-cycle request to program the buffered page |
| prog_page | output | ADDR_W-log2(PAGE_BYTES) | Page address of the buffered burst |
| prog_data | output | PAGE_BYTES*DATA_W | Buffered page, byte i at bits [i*DATA_W +: DATA_W] |
| prog_mask | output | PAGE_BYTES | Loaded-byte mask of the buffered page |
| busy | output | 1 | Programming interval in progress |
| page_mismatch | output | 1 | Sticky flag for a discarded off-page load |

## Verification
The assertions take for granted that the strobe pins follow the memory bus discipline: address and data settle before the strobe opens and stay put until after it closes. They also assume that prog_done is only raised while busy is high. The stimulus drives every pin on the falling clock edge. It holds address and data for two cycles past each strobe release, keeps gaps between loads far shorter than the load window, and raises prog_done only inside a busy interval. The only sequences that break the normal pattern are the ones aimed at a requirement: the sub-threshold glitch, the inhibited strobe, the select-controlled cycle, the off-page load and the load during programming.

// File: rtl/pgl_pkg.sv
package pgl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROG
  } pgl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capAddr;     // combined strobe just opened
    logic openLoad;    // strobe passed the glitch filter, outside programming
    logic commitByte;  // accepted strobe just closed
    logic startProg;   // load window expired
    logic endProg;     // programming interval finished
    logic inProg;      // programming interval running
  } pgl_strb_t;

endpackage

// File: rtl/pgl_ctrl.sv
module pgl_ctrl
  import pgl_pkg::*;
#(
  parameter int GLITCH_CYC = 4,
  parameter int LOAD_CYC   = 15000,
  parameter int PROG_CYC   = 1000000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      weN,
  input  logic      oeN,
  input  logic      progDone,
  output pgl_strb_t strb,
  output logic      progReq,
  output logic      busy
);

  localparam int GW = $clog2(GLITCH_CYC + 1);
  localparam int WW = $clog2(LOAD_CYC);
  localparam int PW = $clog2(PROG_CYC);

  logic [1:0] csSy, weSy, oeSy;
  logic       wrAct, wrActQ, openQ;
  logic [GW-1:0] lowCnt;
  logic [WW-1:0] winCnt;
  logic [PW-1:0] progCnt;
  logic       accept, openLoad, fallEdge, expire, finish;
  pgl_state_e state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSy <= 2'b11;
      weSy <= 2'b11;
      oeSy <= 2'b11;
    end else begin
      csSy <= {csSy[0], csN};
      weSy <= {weSy[0], weN};
      oeSy <= {oeSy[0], oeN};
    end
  end

  // R1: write needs select and write enable low with output enable high
  assign wrAct    = ~csSy[1] & ~weSy[1] & oeSy[1];
  assign fallEdge = ~wrAct & wrActQ;
  assign accept   = wrAct && (lowCnt == GW'(GLITCH_CYC - 1));
  assign openLoad = accept && (state != ST_PROG);
  assign expire   = (state == ST_LOAD) && (winCnt == WW'(LOAD_CYC - 1)) && !openQ && !openLoad;
  assign finish   = (state == ST_PROG) && (progDone || (progCnt == PW'(PROG_CYC - 1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActQ <= 1'b0;
      lowCnt <= '0;
      openQ  <= 1'b0;
    end else begin
      wrActQ <= wrAct;
      if (!wrAct) lowCnt <= '0;
      else if (lowCnt != GW'(GLITCH_CYC)) lowCnt <= lowCnt + 1'b1;
      if (openLoad) openQ <= 1'b1;
      else if (fallEdge) openQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      winCnt  <= '0;
      progCnt <= '0;
      progReq <= 1'b0;
    end else begin
      progReq <= expire;
      if (openLoad) winCnt <= '0;
      else if (state == ST_LOAD && winCnt != WW'(LOAD_CYC - 1)) winCnt <= winCnt + 1'b1;
      if (state == ST_PROG) progCnt <= progCnt + 1'b1;
      else progCnt <= '0;
      unique case (state)
        ST_IDLE: if (openLoad) state <= ST_LOAD;
        ST_LOAD: if (expire) state <= ST_PROG;
        ST_PROG: if (finish) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy            = (state == ST_PROG);
  assign strb.capAddr    = wrAct & ~wrActQ;
  assign strb.openLoad   = openLoad;
  assign strb.commitByte = fallEdge & openQ;
  assign strb.startProg  = expire;
  assign strb.endProg    = finish;
  assign strb.inProg     = (state == ST_PROG);

  a_r7_no_commit_in_prog: assert property (@(posedge clk) disable iff (!rstN)
    strb.inProg |-> !strb.commitByte);
  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy && progDone |=> !busy);
  a_r4_no_early_request: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD) && (winCnt != WW'(LOAD_CYC - 1)) |=> !progReq);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    progReq |=> !progReq);

endmodule

// File: rtl/pgl_dp.sv
module pgl_dp
  import pgl_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             din,
  input  pgl_strb_t                     strb,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] progPage,
  output logic [PAGE_BYTES*DATA_W-1:0]  progData,
  output logic [PAGE_BYTES-1:0]         progMask,
  output logic                          mismatch
);

  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] addrS1, addrS2, pendAddr, openAddr;
  logic [DATA_W-1:0] dinS1, dinS2;
  logic [PAGE_W-1:0] burstPage;
  logic [DATA_W-1:0] pageBuf [PAGE_BYTES];
  logic              byteMask [PAGE_BYTES];
  logic [OFS_W-1:0]  byteIdx;
  logic              firstByte, takeByte;

  // same two-stage delay as the strobes so address and data line up
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrS1 <= '0; addrS2 <= '0;
      dinS1  <= '0; dinS2  <= '0;
    end else begin
      addrS1 <= addr;  addrS2 <= addrS1;
      dinS1  <= din;   dinS2  <= dinS1;
    end
  end

  // R2: address taken when the combined strobe opens
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr <= '0;
      openAddr <= '0;
    end else begin
      if (strb.capAddr) pendAddr <= addrS2;
      if (strb.openLoad) openAddr <= strb.capAddr ? addrS2 : pendAddr;
    end
  end

  assign byteIdx   = openAddr[OFS_W-1:0];
  assign firstByte = (progMask == '0);
  assign takeByte  = strb.commitByte && (firstByte || openAddr[ADDR_W-1:OFS_W] == burstPage);

  // R8: first load of a burst fixes the page; off-page loads are dropped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstPage <= '0;
      mismatch  <= 1'b0;
    end else begin
      if (strb.commitByte && firstByte) burstPage <= openAddr[ADDR_W-1:OFS_W];
      if (strb.commitByte && !takeByte) mismatch <= 1'b1;
    end
  end

  // R3, R11: data taken when the strobe closes, slot chosen by low bits
  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pageBuf[i]  <= '0;
        byteMask[i] <= 1'b0;
      end else if (strb.endProg) begin
        byteMask[i] <= 1'b0;
      end else if (takeByte && byteIdx == OFS_W'(i)) begin
        pageBuf[i]  <= dinS2;
        byteMask[i] <= 1'b1;
      end
    end
    assign progData[i*DATA_W +: DATA_W] = pageBuf[i];
    assign progMask[i] = byteMask[i];
  end

  assign progPage = burstPage;

  a_r5_request_not_empty: assert property (@(posedge clk) disable iff (!rstN)
    strb.startProg |-> (progMask != '0));
  a_r7_page_frozen: assert property (@(posedge clk) disable iff (!rstN)
    strb.inProg && $past(strb.inProg) |-> $stable(progMask) && $stable(progData));
  a_r8_sticky_flag: assert property (@(posedge clk) disable iff (!rstN)
    $past(mismatch) |-> mismatch);

endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
  import pgl_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64,
  parameter int GLITCH_CYC = 4,
  parameter int LOAD_CYC   = 15000,
  parameter int PROG_CYC   = 1000000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cs_n,
  input  logic                                 we_n,
  input  logic                                 oe_n,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [DATA_W-1:0]                    din,
  input  logic                                 prog_done,
  output logic                                 prog_req,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] prog_page,
  output logic [PAGE_BYTES*DATA_W-1:0]         prog_data,
  output logic [PAGE_BYTES-1:0]                prog_mask,
  output logic                                 busy,
  output logic                                 page_mismatch
);

  pgl_strb_t strb;

  pgl_ctrl #(
    .GLITCH_CYC(GLITCH_CYC),
    .LOAD_CYC  (LOAD_CYC),
    .PROG_CYC  (PROG_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rst_n),
    .csN     (cs_n),
    .weN     (we_n),
    .oeN     (oe_n),
    .progDone(prog_done),
    .strb    (strb),
    .progReq (prog_req),
    .busy    (busy)
  );

  pgl_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rst_n),
    .addr    (addr),
    .din     (din),
    .strb    (strb),
    .progPage(prog_page),
    .progData(prog_data),
    .progMask(prog_mask),
    .mismatch(page_mismatch)
  );

  a_r6_busy_with_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> prog_req);

endmodule

// File: tb/test_page_load_ctrl.sv
`timescale 1ns/1ps
module test_page_load_ctrl;

  localparam int AW = 12, DW = 8, PB = 16, G = 3, L = 40, P = 60;
  localparam int LAT = 2 + G + L;

  logic clk = 1'b0, rstN = 1'b0;
  logic csN = 1'b1, weN = 1'b1, oeN = 1'b1, progDone = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic progReq, busy, mismatch;
  logic [7:0] progPage;
  logic [PB*DW-1:0] progData;
  logic [PB-1:0] progMask;

  int nChk = 0, nFail = 0, cyc = 0, lastLowCyc = 0;

  logic [7:0]  shBuf [PB];
  logic [PB-1:0] shMask = '0;
  logic [7:0]  shPage = '0;
  logic [7:0]  qPage [$];
  logic [PB-1:0] qMask [$];
  logic [PB*DW-1:0] qData [$];

  page_load_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .GLITCH_CYC(G),
                   .LOAD_CYC(L), .PROG_CYC(P)) i_page_load_ctrl (
    .clk(clk), .rst_n(rstN), .cs_n(csN), .we_n(weN), .oe_n(oeN), .addr(addr), .din(din),
    .prog_done(progDone), .prog_req(progReq), .prog_page(progPage), .prog_data(progData),
    .prog_mask(progMask), .busy(busy), .page_mismatch(mismatch));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected pages as program requests appear
  always @(negedge clk) begin
    if (rstN && progReq) begin
      if (qPage.size() == 0) chk(1'b0, "R7", "unexpected program request", 1, 0);
      else begin
        logic [7:0] ePg;
        logic [PB-1:0] eMk;
        logic [PB*DW-1:0] eDt;
        ePg = qPage.pop_front(); eMk = qMask.pop_front(); eDt = qData.pop_front();
        chk(cyc - lastLowCyc == LAT, "R4", "request latency", cyc - lastLowCyc, LAT);
        chk(progPage == ePg, "R5", "page", progPage, ePg);
        chk(progMask == eMk, "R5", "mask", progMask, eMk);
        for (int i = 0; i < PB; i++)
          if (eMk[i]) chk(progData[i*8 +: 8] == eDt[i*8 +: 8], "R3", "byte", progData[i*8 +: 8], eDt[i*8 +: 8]);
        chk(busy == 1'b1, "R6", "busy with request", busy, 1);
      end
    end
  end

  task automatic strobe(input logic [AW-1:0] a, input logic [7:0] d, input int lowCyc,
                        input bit oeLow, input bit mark);
    @(negedge clk);
    addr = a; din = d; oeN = oeLow ? 1'b0 : 1'b1; csN = 1'b0; weN = 1'b0;
    if (mark) lastLowCyc = cyc;
    repeat (lowCyc) @(negedge clk);
    csN = 1'b1; weN = 1'b1;
    repeat (2) @(negedge clk);
    oeN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic model(input logic [AW-1:0] a, input logic [7:0] d);
    if (shMask == '0) shPage = a[AW-1:4];
    if (a[AW-1:4] == shPage) begin
      shBuf[a[3:0]] = d;
      shMask[a[3:0]] = 1'b1;
    end
  endtask

  task automatic loadByte(input logic [AW-1:0] a, input logic [7:0] d, input int lowCyc);
    strobe(a, d, lowCyc, 1'b0, 1'b1);
    model(a, d);
  endtask

  task automatic closeBurst();
    logic [PB*DW-1:0] v;
    v = '0;
    for (int i = 0; i < PB; i++) v[i*8 +: 8] = shBuf[i];
    qPage.push_back(shPage); qMask.push_back(shMask); qData.push_back(v);
    shMask = '0;
  endtask

  task automatic waitBusy(input int doneAt, input int expLen);
    int n;
    n = 0;
    for (int k = 0; k < 200 && !busy; k++) @(negedge clk);
    while (busy && n < 500) begin
      n++;
      if (doneAt != 0 && n == doneAt) progDone = 1'b1;
      @(negedge clk);
    end
    progDone = 1'b0;
    chk(n == expLen, "R6", "busy length", n, expLen);
  endtask

  task automatic quietFor(input int cycles, input string req);
    bit seen;
    seen = 1'b0;
    repeat (cycles) begin
      @(negedge clk);
      if (busy || progReq) seen = 1'b1;
    end
    chk(!seen, req, "no activity", seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < PB; i++) shBuf[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(busy == 0, "R10", "busy", busy, 0);
    chk(progReq == 0, "R10", "prog_req", progReq, 0);
    chk(mismatch == 0, "R10", "mismatch", mismatch, 0);
    chk(progMask == 0, "R10", "mask", progMask, 0);

    // R5: sequential burst with an overwrite
    for (int i = 0; i < 6; i++) loadByte({8'h12, 4'(i)}, 8'h10 + 8'(i), 4);
    loadByte({8'h12, 4'd2}, 8'hE2, 4);
    closeBurst();
    waitBusy(0, P);

    // R9: short glitch alone starts nothing
    strobe({8'h34, 4'd7}, 8'h77, G - 1, 1'b0, 1'b0);
    quietFor(LAT + 10, "R9");

    // R9 exact threshold accepted, R1 inhibited strobe, R6 early done
    loadByte({8'h34, 4'd3}, 8'h33, G);
    strobe({8'h34, 4'd11}, 8'hBB, 4, 1'b1, 1'b0);   // R1: oe low, ignored
    strobe({8'h34, 4'd12}, 8'hCC, G - 1, 1'b0, 1'b0); // R9: glitch inside burst
    loadByte({8'h34, 4'd9}, 8'h99, 4);
    closeBurst();
    waitBusy(7, 7);

    // R8 off-page load dropped, R11 top offset
    loadByte({8'h40, 4'd1}, 8'h41, 4);
    strobe({8'h41, 4'd2}, 8'h42, 4, 1'b0, 1'b1);
    loadByte({8'h40, 4'd15}, 8'h4F, 4);
    chk(mismatch == 1, "R8", "flag set", mismatch, 1);
    closeBurst();
    waitBusy(0, P);

    // R7: load during programming is ignored
    loadByte({8'h50, 4'd4}, 8'h54, 4);
    closeBurst();
    for (int k = 0; k < 200 && !busy; k++) @(negedge clk);
    strobe({8'h50, 4'd5}, 8'h55, 4, 1'b0, 1'b0);
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
    chk(progMask == 16'h0, "R7", "mask cleared, no stray byte", progMask, 0);
    quietFor(LAT + 10, "R7");

    // R2/R3: select-controlled cycle; address at later fall, data at first rise
    @(negedge clk);
    addr = {8'h55, 4'd0}; din = 8'h11; weN = 1'b0;
    repeat (4) @(negedge clk);
    addr = {8'h56, 4'd4};
    @(negedge clk);
    csN = 1'b0; din = 8'hA5; lastLowCyc = cyc;
    repeat (5) @(negedge clk);
    csN = 1'b1;
    @(negedge clk);
    din = 8'h3C;
    repeat (2) @(negedge clk);
    weN = 1'b1;
    repeat (4) @(negedge clk);
    model({8'h56, 4'd4}, 8'hA5);
    closeBurst();
    waitBusy(0, P);
    chk(progPage == 8'h56, "R2", "page from later fall", progPage, 8'h56);
    chk(progData[4*8 +: 8] == 8'hA5, "R3", "byte from first rise", progData[4*8 +: 8], 8'hA5);
    chk(mismatch == 1, "R8", "flag still set", mismatch, 1);
    chk(qPage.size() == 0, "R5", "all requests seen", qPage.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule